// File: doc/BRIEF.md
# Dual-Channel Converter Output Word Formatter

This block sits between the back end of a two-channel 14-bit sampling converter and its output drivers. Each cycle it takes one raw offset-binary sample per channel, along with a flag from the converter that the sample went past full scale. Over-range samples are forced to the matching full-scale code. Each sample is then recoded into the selected output coding. The word and its over-range flag then pass through a fixed pipeline, so they leave the block a set number of clock cycles after they entered.

The output coding for each channel comes from a strap pin until software writes that channel's configuration register. After the write, the register setting takes over, and a reset hands control back to the strap pin. A global output-disable pin turns off the drivers of both channels. The drivers covered are the data drivers and the data-clock drivers. A bit in each channel's register turns off that channel's drivers alone. The block reports this as a per-channel drive-enable signal for the pad ring.

Top module: `adc_out_formatter`

## Requirements
- R1: During and right after reset, every output word is 0, every over-range output is 0, and the drive enables follow the pins alone. With the disable pin low, both are 1.
- R2: While a channel's register has not been written since reset, the strap pin sets its coding. Low selects offset binary and high selects twos complement.
- R3: A write to a channel's register (address 0x14 for channel 0, 0x15 for channel 1) sets the coding from bits [1:0]. The codes are 0 for offset binary, 1 for twos complement, 2 for Gray, and 3 for offset binary. From then on the strap pin has no effect on that channel.
- R4: Twos complement output is the offset-binary word with bit 13 inverted. Mid-scale 0x2000 becomes 0x0000, and 0x0000 becomes 0x2000.
- R5: Gray output is the offset-binary word b XORed with b shifted right by one.
- R6: An over-range sample with input bit 13 high is forced to the top code: 0x3FFF offset, 0x1FFF twos, 0x2000 Gray. With bit 13 low it is forced to the bottom code: 0x0000 offset, 0x2000 twos, 0x0000 Gray. The over-range output is 1 in both cases and 0 otherwise.
- R7: A sample and its over-range flag appear at the outputs exactly 12 clock cycles after they are presented, and stay there for exactly one cycle.
- R8: While the global disable pin is high, both drive enables are 0.
- R9: Bit 4 of a channel's register, when 1, clears that channel's drive enable only.
- R10: A write to any address other than the two channel registers changes neither the codings nor the drive enables.
- R11: A reset returns a channel that software has configured to strap-pin control of its coding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_pin | input | 1 | Coding strap: 0 offset binary, 1 twos complement |
| oeb_pin | input | 1 | Global driver disable, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| raw_data | input | 2x14 | Raw offset-binary samples, one per channel |
| ovr_in | input | 2 | Per-sample over-range indication from the converter |
| dout | output | 2x14 | Formatted output words |
| ovr_out | output | 2 | Over-range flag, aligned with dout |
| drive_en | output | 2 | Data and data-clock driver enable per channel |

## Verification
The vector table runs each of the three codings, plus the spare code, over these inputs:
- mid-scale
- both rails
- an asymmetric mid-range value
- small values whose Gray code differs from the binary word

These inputs separate a bit-13 inversion from a full negation, and a right shift from a left shift. Over-range samples are applied with both polarities of bit 13, and a full-scale sample is applied without the flag. This separates clamping from the flag pass-through and shows that the flag alone triggers clamping. A one-cycle impulse set against a steady background pins the latency at 12 rather than 11 or 13. Separate writes to each channel show that the strap override, the three-state bit and an unrelated address act on the intended channel only.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    localparam int SAMPLE_W = 14;
    localparam int MSB      = SAMPLE_W - 1;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        FMT_OFFSET = 2'd0,
        FMT_TWOS   = 2'd1,
        FMT_GRAY   = 2'd2,
        FMT_SPARE  = 2'd3
    } fmt_e;

    typedef struct packed {
        logic    ovr;
        sample_t data;
    } word_t;

    localparam int WORD_W = $bits(word_t);

    typedef struct packed {
        logic sw_owned;
        logic tri_bar;
        fmt_e fmt;
    } ch_cfg_t;

    // Force an over-range sample to the rail its sign points at.
    function automatic sample_t clamp_sample(sample_t raw, logic ovr);
        if (!ovr) begin
            return raw;
        end
        return raw[MSB] ? {SAMPLE_W{1'b1}} : {SAMPLE_W{1'b0}};
    endfunction

    function automatic sample_t to_twos(sample_t b);
        return {~b[MSB], b[MSB-1:0]};
    endfunction

    function automatic sample_t to_gray(sample_t b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/adc_fmt_regs.sv
module adc_fmt_regs
    import adc_fmt_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int REG_BASE = 'h14,
    parameter int TRI_BIT  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 fmt_pin,
    input  logic                 oeb_pin,
    output fmt_e [NCH-1:0]       ch_fmt,
    output logic [NCH-1:0]       drive_en
);

    localparam fmt_e STRAP_HI = FMT_TWOS;
    localparam fmt_e STRAP_LO = FMT_OFFSET;

    fmt_e strap_fmt;
    assign strap_fmt = fmt_pin ? STRAP_HI : STRAP_LO;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_BASE + c);

        ch_cfg_t cfg_q;
        logic    hit;

        assign hit = we && (addr == MY_ADDR);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q <= '{sw_owned: 1'b0, tri_bar: 1'b0, fmt: FMT_OFFSET};
            end else if (hit) begin
                cfg_q.sw_owned <= 1'b1;
                cfg_q.tri_bar  <= wdata[TRI_BIT];
                cfg_q.fmt      <= fmt_e'(wdata[1:0]);
            end
        end

        assign ch_fmt[c]   = cfg_q.sw_owned ? cfg_q.fmt : strap_fmt;
        assign drive_en[c] = !oeb_pin && !cfg_q.tri_bar;
    end

endmodule

// File: rtl/adc_fmt_lane.sv
module adc_fmt_lane
    import adc_fmt_pkg::*;
(
    input  sample_t raw,
    input  logic    ovr_in,
    input  fmt_e    fmt,
    output word_t   word
);

    sample_t clamped;

    always_comb begin
        clamped   = clamp_sample(raw, ovr_in);
        word.ovr  = ovr_in;
        unique case (fmt)
            FMT_TWOS: word.data = to_twos(clamped);
            FMT_GRAY: word.data = to_gray(clamped);
            default:  word.data = clamped;
        endcase
    end

endmodule

// File: rtl/adc_fmt_delay.sv
module adc_fmt_delay #(
    parameter int W     = 15,
    parameter int DEPTH = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= d;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
    import adc_fmt_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int LATENCY  = 12,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int REG_BASE = 'h14,
    parameter int TRI_BIT  = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             fmt_pin,
    input  logic                             oeb_pin,
    input  logic                             cfg_we,
    input  logic [ADDR_W-1:0]                cfg_addr,
    input  logic [DATA_W-1:0]                cfg_wdata,
    input  logic [NCH-1:0][SAMPLE_W-1:0]     raw_data,
    input  logic [NCH-1:0]                   ovr_in,
    output logic [NCH-1:0][SAMPLE_W-1:0]     dout,
    output logic [NCH-1:0]                   ovr_out,
    output logic [NCH-1:0]                   drive_en
);

    fmt_e [NCH-1:0] ch_fmt;

    adc_fmt_regs #(
        .NCH      (NCH),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .REG_BASE (REG_BASE),
        .TRI_BIT  (TRI_BIT)
    ) i_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .fmt_pin  (fmt_pin),
        .oeb_pin  (oeb_pin),
        .ch_fmt   (ch_fmt),
        .drive_en (drive_en)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        word_t fmt_word;
        word_t out_word;

        adc_fmt_lane i_lane (
            .raw    (raw_data[c]),
            .ovr_in (ovr_in[c]),
            .fmt    (ch_fmt[c]),
            .word   (fmt_word)
        );

        adc_fmt_delay #(
            .W     (WORD_W),
            .DEPTH (LATENCY)
        ) i_delay (
            .clk (clk),
            .rst (rst),
            .d   (fmt_word),
            .q   (out_word)
        );

        assign dout[c]    = out_word.data;
        assign ovr_out[c] = out_word.ovr;
    end

endmodule

// File: rtl/adc_out_formatter_chk.sv
module adc_out_formatter_chk
    import adc_fmt_pkg::*;
#(
    parameter int NCH     = 2,
    parameter int LATENCY = 12
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         cfg_we,
    input logic                         oeb_pin,
    input logic [NCH-1:0][SAMPLE_W-1:0] dout,
    input logic [NCH-1:0]               ovr_out,
    input logic [NCH-1:0]               drive_en
);

    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [CNT_W-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                                since_rst <= '0;
        else if (since_rst != CNT_W'(LATENCY))  since_rst <= since_rst + 1'b1;
    end

    // R1 / R7: nothing leaves the pipeline before it has filled after reset.
    a_r7_flush_quiet: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CNT_W'(LATENCY)) |-> (dout == '0 && ovr_out == '0));

    // R8
    a_r8_oeb_disables: assert property (@(posedge clk) disable iff (rst)
        oeb_pin |-> (drive_en == '0));

    // R9 / R10: drive enables move only after a write or a pin change.
    a_r9_drive_stable: assert property (@(posedge clk) disable iff (rst)
        (!cfg_we ##1 $stable(oeb_pin)) |-> $stable(drive_en));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R6: a flagged word always carries one of the rail codes.
        a_r6_clamp_code: assert property (@(posedge clk) disable iff (rst)
            ovr_out[c] |-> (dout[c] == 14'h0000 || dout[c] == 14'h3FFF ||
                            dout[c] == 14'h2000 || dout[c] == 14'h1FFF));
    end

endmodule

bind adc_out_formatter adc_out_formatter_chk #(
    .NCH     (NCH),
    .LATENCY (LATENCY)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .oeb_pin  (oeb_pin),
    .dout     (dout),
    .ovr_out  (ovr_out),
    .drive_en (drive_en)
);

// File: tb/test_adc_out_formatter.sv
module test_adc_out_formatter;

    localparam int LAT = 12;
    localparam int NV  = 20;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                fmt_pin = 1'b0;
    logic                oeb_pin = 1'b0;
    logic                cfg_we = 1'b0;
    logic [7:0]          cfg_addr = '0;
    logic [7:0]          cfg_wdata = '0;
    logic [1:0][13:0]    raw_data = '0;
    logic [1:0]          ovr_in = '0;
    logic [1:0][13:0]    dout;
    logic [1:0]          ovr_out;
    logic [1:0]          drive_en;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    adc_out_formatter i_adc_out_formatter (
        .clk       (clk),
        .rst       (rst),
        .fmt_pin   (fmt_pin),
        .oeb_pin   (oeb_pin),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .raw_data  (raw_data),
        .ovr_in    (ovr_in),
        .dout      (dout),
        .ovr_out   (ovr_out),
        .drive_en  (drive_en)
    );

    // {coding[1:0], raw[13:0], ovr_in, expected word[13:0], expected flag}
    localparam logic [31:0] VEC [NV] = '{
        {2'd0, 14'h2000, 1'b0, 14'h2000, 1'b0},   // R3 offset mid-scale
        {2'd0, 14'h1234, 1'b0, 14'h1234, 1'b0},
        {2'd0, 14'h3FFF, 1'b0, 14'h3FFF, 1'b0},   // R6 rail without flag
        {2'd0, 14'h0005, 1'b1, 14'h0000, 1'b1},   // R6 below range
        {2'd0, 14'h3FF0, 1'b1, 14'h3FFF, 1'b1},   // R6 above range
        {2'd1, 14'h2000, 1'b0, 14'h0000, 1'b0},   // R4 mid-scale
        {2'd1, 14'h0000, 1'b0, 14'h2000, 1'b0},   // R4
        {2'd1, 14'h3FFF, 1'b0, 14'h1FFF, 1'b0},   // R4
        {2'd1, 14'h1234, 1'b0, 14'h3234, 1'b0},   // R4
        {2'd1, 14'h0010, 1'b1, 14'h2000, 1'b1},   // R6
        {2'd1, 14'h3000, 1'b1, 14'h1FFF, 1'b1},   // R6
        {2'd2, 14'h0001, 1'b0, 14'h0001, 1'b0},   // R5
        {2'd2, 14'h0002, 1'b0, 14'h0003, 1'b0},   // R5
        {2'd2, 14'h2000, 1'b0, 14'h3000, 1'b0},   // R5
        {2'd2, 14'h3FFF, 1'b0, 14'h2000, 1'b0},   // R5
        {2'd2, 14'h1234, 1'b0, 14'h1B2E, 1'b0},   // R5
        {2'd2, 14'h3800, 1'b1, 14'h2000, 1'b1},   // R6
        {2'd2, 14'h0100, 1'b1, 14'h0000, 1'b1},   // R6
        {2'd3, 14'h0ABC, 1'b0, 14'h0ABC, 1'b0},   // R3 spare code
        {2'd3, 14'h2000, 1'b0, 14'h2000, 1'b0}    // R3 spare code
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put(input logic [13:0] r, input logic o);
        raw_data = {r, r};
        ovr_in   = {o, o};
    endtask

    task automatic wait_lat();
        repeat (LAT) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        put(14'h2000, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 dout", 32'(dout), 32'h0);
        check("R1 ovr", 32'(ovr_out), 32'h0);
        check("R1 drive", 32'(drive_en), 32'h3);

        // R2: strap selects coding
        @(negedge clk);
        fmt_pin = 1'b0; put(14'h2000, 1'b0);
        wait_lat();
        check("R2 strap low", 32'(dout), {4'h0, 14'h2000, 14'h2000});
        fmt_pin = 1'b1;
        wait_lat();
        check("R2 strap high", 32'(dout), {4'h0, 14'h0000, 14'h0000});

        // R3: register write on ch0 overrides strap, ch1 still strapped
        wr(8'h14, 8'h00);
        wait_lat();
        check("R3 override ch0", 32'(dout[0]), 32'h2000);
        check("R3 ch1 strapped", 32'(dout[1]), 32'h0000);

        // Table walk: R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            wr(8'h14, {6'b0, VEC[v][31:30]});
            wr(8'h15, {6'b0, VEC[v][31:30]});
            put(VEC[v][29:16], VEC[v][15]);
            wait_lat();
            for (int c = 0; c < 2; c++) begin
                check($sformatf("R3/R4/R5/R6 vec %0d ch%0d", v, c),
                      {17'h0, ovr_out[c], dout[c]},
                      {17'h0, VEC[v][0], VEC[v][14:1]});
            end
        end

        // R7: exact latency of a one-cycle impulse
        wr(8'h14, 8'h00);
        wr(8'h15, 8'h00);
        put(14'h0100, 1'b0);
        repeat (LAT + 1) @(negedge clk);
        put(14'h3F00, 1'b1);
        @(negedge clk);
        put(14'h0100, 1'b0);
        repeat (LAT - 2) @(negedge clk);
        check("R7 cycle 11", {17'h0, ovr_out[0], dout[0]}, {17'h0, 1'b0, 14'h0100});
        @(negedge clk);
        check("R7 cycle 12", {17'h0, ovr_out[0], dout[0]}, {17'h0, 1'b1, 14'h3FFF});
        check("R7 cycle 12 ch1", {17'h0, ovr_out[1], dout[1]}, {17'h0, 1'b1, 14'h3FFF});
        @(negedge clk);
        check("R7 cycle 13", {17'h0, ovr_out[0], dout[0]}, {17'h0, 1'b0, 14'h0100});

        // R8: global disable
        oeb_pin = 1'b1;
        #1;
        check("R8 oeb high", 32'(drive_en), 32'h0);
        @(negedge clk);
        oeb_pin = 1'b0;
        #1;
        check("R8 oeb low", 32'(drive_en), 32'h3);

        // R9: per-channel three-state bit
        wr(8'h14, 8'h10);
        #1;
        check("R9 ch0 off", 32'(drive_en), 32'h2);
        wr(8'h15, 8'h10);
        #1;
        check("R9 both off", 32'(drive_en), 32'h0);
        wr(8'h14, 8'h00);
        #1;
        check("R9 ch0 back", 32'(drive_en), 32'h1);
        wr(8'h15, 8'h00);
        #1;
        check("R9 ch1 back", 32'(drive_en), 32'h3);

        // R10: unrelated address is ignored
        wr(8'h20, 8'h11);
        #1;
        check("R10 drive", 32'(drive_en), 32'h3);
        put(14'h2000, 1'b0);
        wait_lat();
        check("R10 coding", 32'(dout), {4'h0, 14'h2000, 14'h2000});

        // R11: reset restores strap control (strap high -> twos)
        fmt_pin = 1'b1;
        do_reset();
        put(14'h2000, 1'b0);
        wait_lat();
        check("R11 strap after reset", 32'(dout), {4'h0, 14'h0000, 14'h0000});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule